// File: doc/BRIEF.md
# Bitwise Bus Arbitration and Break Controller

This block serves one node on a shared serial line where the low level is dominant: any node that drives zero pulls the whole line to zero, and the line rests at mark (one) when nobody drives it. The node sends one byte per frame and compares every bit it puts on the line with the bit it reads back. A node that drives one but reads zero has been overridden by a node with a higher-priority byte. It releases the line to mark for the rest of that frame and keeps listening. Because frames go out most significant bit first, the lowest value wins a collision.

Bit timing is generated outside the block. A one-cycle `bit_tick` strobe ends each bit slot. On that strobe the block samples `rx_bit` for the slot just finished, and it changes `bus_drive` for the slot that follows. A frame is a zero start bit, `DATA_W` data bits and a one stop bit. The node may open a new arbitration only while the external idle indication is high. Once it has won, it may chain further bytes without waiting for idle. The idle indication also clears the won and lost flags and the byte counter.

A node that must break into a long transmission raises `brk_req`. Once the byte counter shows that `BRK_AFTER` valid frames have passed since idle, the node drives `BRK_BITS` zero slots onto the line. This forces a collision that the sender sees as lost arbitration. A break request may fire only one break. A second break needs the request to be dropped and raised again.

Top module: `sbarb_node`

## Requirements
- R1: After reset `bus_drive` is 1 (mark), and `busy`, `won`, `lost`, `brk_active`, `rx_valid` and `byte_count` are 0. `bus_drive` stays 1 whenever the node is neither sending a frame nor breaking.
- R2: A `tx_start` pulse is accepted only when the transmitter is free and either `idle_in` is 1 or `won` is 1. Otherwise it is ignored: `busy` stays 0 and `bus_drive` stays 1.
- R3: An accepted byte goes out from the first `bit_tick` at which the receiver is between frames and `rx_bit` reads 1. The frame is one 0 start slot, then the data bits most significant first, then one 1 stop slot, each lasting one tick period. `bus_drive` changes only in the cycle after a `bit_tick`.
- R4: If the node drove 1 in a data or stop slot and `rx_bit` read 0 at the tick that closes it, `lost` goes to 1 and `won` goes to 0. `bus_drive` then stays 1 until the frame ends.
- R5: If a frame reaches its stop tick with no mismatch, `won` goes to 1.
- R6: The receiver decodes every frame on the line, whoever sends it, most significant bit first. When the stop slot reads 1 it pulses `rx_valid` for one cycle and presents the byte on `rx_data`. A stop slot that reads 0 yields no pulse.
- R7: `byte_count` counts valid frames, saturates at all ones, and is forced to 0 in every cycle where `idle_in` is 1.
- R8: `idle_in` at 1 clears `won` and `lost`. A node that lost cannot start again until idle.
- R9: With `brk_req` at 1, `byte_count` >= `BRK_AFTER` and the receiver between frames at a tick, the transmitter drives 0 for exactly `BRK_BITS` slots. `brk_active` is 1 during them. This takes priority over a pending byte.
- R10: Only one break is produced per assertion of `brk_req`. Another break needs `brk_req` to return to 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe that closes each bit slot |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | DATA_W | Byte to send |
| idle_in | input | 1 | Line-idle indication, active high |
| brk_req | input | 1 | Request to force a break |
| rx_bit | input | 1 | Value read back from the line |
| bus_drive | output | 1 | Value driven onto the line (1 = release) |
| busy | output | 1 | Byte pending, frame in progress, or break in progress |
| won | output | 1 | Last frame sent without collision |
| lost | output | 1 | Arbitration lost since last idle |
| brk_active | output | 1 | Break slots being driven |
| rx_valid | output | 1 | One-cycle pulse with a decoded byte |
| rx_data | output | DATA_W | Last valid decoded byte |
| byte_count | output | CNT_W | Valid frames seen since idle, saturating |

Transmitter states: T_IDLE, T_START, T_DATA, T_STOP, T_LOST, T_BREAK. The transitions on a tick are:
- T_IDLE→T_BREAK when a break is due.
- T_IDLE→T_START when a pending byte launches.
- T_START→T_DATA.
- T_DATA→T_LOST on a mismatch.
- T_DATA→T_STOP after the last data bit.
- T_STOP→T_IDLE.
- T_LOST→T_IDLE at the receiver's stop tick.
- T_BREAK→T_IDLE after the last break slot.

Receiver states: R_GAP, R_DATA, R_STOP. The transitions on a tick are:
- R_GAP→R_DATA when a zero is read.
- R_DATA→R_STOP after the last data bit.
- R_STOP→R_GAP.

## Verification
The bench builds the block with an 8-bit data width, `BRK_AFTER` of 3 and `BRK_BITS` of 10. It narrows `CNT_W` to 3, so the counter reaches its saturation value of 7 within a nine-frame burst. A behavioural opponent node shares the line through a wired-AND. It backs off when it is overridden. This makes both directions of arbitration loss reachable. It also lets a break land exactly on the fourth frame of a back-to-back stream, and lets the bench confirm that no second break follows while the request stays high.

// File: rtl/sbarb_pkg.sv
package sbarb_pkg;

    typedef enum logic [2:0] {
        T_IDLE,
        T_START,
        T_DATA,
        T_STOP,
        T_LOST,
        T_BREAK
    } tx_state_t;

    typedef enum logic [1:0] {
        R_GAP,
        R_DATA,
        R_STOP
    } rx_state_t;

endpackage

// File: rtl/sbarb_rx.sv
module sbarb_rx
    import sbarb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rx_bit,
    input  logic              idle_in,
    output logic              in_gap,
    output logic              at_stop,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic [CNT_W-1:0]  byte_count
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    rx_state_t          st_q, st_d;
    logic [IDX_W-1:0]   idx_q;
    logic [DATA_W-1:0]  sh_q;
    logic               frame_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= R_GAP;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (bit_tick) begin
            unique case (st_q)
                R_GAP:   if (!rx_bit) st_d = R_DATA;
                R_DATA:  if (idx_q == LAST_IDX) st_d = R_STOP;
                R_STOP:  st_d = R_GAP;
                default: st_d = R_GAP;
            endcase
        end
    end

    assign frame_ok = bit_tick && (st_q == R_STOP) && rx_bit;

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            sh_q       <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            byte_count <= '0;
        end else begin
            rx_valid <= frame_ok;
            if (bit_tick && st_q == R_GAP)
                idx_q <= '0;
            else if (bit_tick && st_q == R_DATA)
                idx_q <= idx_q + 1'b1;
            if (bit_tick && st_q == R_DATA)
                sh_q <= {sh_q[DATA_W-2:0], rx_bit};
            if (frame_ok)
                rx_data <= sh_q;
            if (idle_in)
                byte_count <= '0;
            else if (frame_ok && byte_count != CNT_MAX)
                byte_count <= byte_count + 1'b1;
        end
    end

    assign in_gap  = (st_q == R_GAP);
    assign at_stop = (st_q == R_STOP);

    // R7: idle forces the counter to zero on the next cycle
    a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(idle_in) |-> (byte_count == '0));

    // R7: the counter moves only on a valid frame
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(idle_in) && !$past(frame_ok)) |-> $stable(byte_count));

    // R6: a decoded byte is flagged for a single cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/sbarb_tx.sv
module sbarb_tx
    import sbarb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 4,
    parameter int BRK_AFTER = 3,
    parameter int BRK_BITS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rx_bit,
    input  logic              idle_in,
    input  logic              in_gap,
    input  logic              at_stop,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              brk_req,
    output logic              bus_drive,
    output logic              busy,
    output logic              won,
    output logic              lost,
    output logic              brk_active
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int BRK_W = (BRK_BITS > 1) ? $clog2(BRK_BITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_W - 1);
    localparam logic [BRK_W-1:0] BRK_LAST  = BRK_W'(BRK_BITS - 1);
    localparam logic [CNT_W-1:0] BRK_AFT_C = CNT_W'(BRK_AFTER);

    tx_state_t          st_q, st_d;
    logic               pend_q;
    logic [DATA_W-1:0]  dbuf_q;
    logic [IDX_W-1:0]   idx_q;
    logic [BRK_W-1:0]   bcnt_q;
    logic               drive_q;
    logic               won_q;
    logic               lost_q;
    logic               used_q;

    logic accept;
    logic brk_go;
    logic launch;
    logic mismatch;

    assign accept   = tx_start && (st_q == T_IDLE) && !pend_q && (idle_in || won_q);
    assign brk_go   = bit_tick && (st_q == T_IDLE) && brk_req && !used_q && in_gap
                      && (byte_count >= BRK_AFT_C);
    assign launch   = bit_tick && (st_q == T_IDLE) && !brk_go && pend_q && in_gap && rx_bit;
    assign mismatch = drive_q && !rx_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (bit_tick) begin
            unique case (st_q)
                T_IDLE: begin
                    if (brk_go)      st_d = T_BREAK;
                    else if (launch) st_d = T_START;
                end
                T_START: st_d = T_DATA;
                T_DATA: begin
                    if (mismatch)               st_d = T_LOST;
                    else if (idx_q == LAST_IDX) st_d = T_STOP;
                end
                T_STOP:  st_d = T_IDLE;
                T_LOST:  if (at_stop) st_d = T_IDLE;
                T_BREAK: if (bcnt_q == BRK_LAST) st_d = T_IDLE;
                default: st_d = T_IDLE;
            endcase
        end
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            dbuf_q  <= '0;
            idx_q   <= '0;
            bcnt_q  <= '0;
            drive_q <= 1'b1;
            won_q   <= 1'b0;
            lost_q  <= 1'b0;
            used_q  <= 1'b0;
        end else begin
            if (bit_tick) begin
                unique case (st_q)
                    T_IDLE: begin
                        if (brk_go) begin
                            drive_q <= 1'b0;
                            bcnt_q  <= '0;
                            used_q  <= 1'b1;
                        end else if (launch) begin
                            drive_q <= 1'b0;
                            pend_q  <= 1'b0;
                        end
                    end
                    T_START: begin
                        drive_q <= dbuf_q[DATA_W-1];
                        dbuf_q  <= dbuf_q << 1;
                        idx_q   <= '0;
                    end
                    T_DATA: begin
                        if (mismatch) begin
                            drive_q <= 1'b1;
                            lost_q  <= 1'b1;
                            won_q   <= 1'b0;
                        end else if (idx_q == LAST_IDX) begin
                            drive_q <= 1'b1;
                        end else begin
                            drive_q <= dbuf_q[DATA_W-1];
                            dbuf_q  <= dbuf_q << 1;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                    T_STOP: begin
                        drive_q <= 1'b1;
                        if (mismatch) begin
                            lost_q <= 1'b1;
                            won_q  <= 1'b0;
                        end else begin
                            won_q  <= 1'b1;
                        end
                    end
                    T_LOST: drive_q <= 1'b1;
                    T_BREAK: begin
                        if (bcnt_q == BRK_LAST) drive_q <= 1'b1;
                        else                    bcnt_q  <= bcnt_q + 1'b1;
                    end
                    default: drive_q <= 1'b1;
                endcase
            end
            if (accept) begin
                pend_q <= 1'b1;
                dbuf_q <= tx_data;
            end
            if (!brk_req)
                used_q <= 1'b0;
            if (idle_in) begin
                won_q  <= 1'b0;
                lost_q <= 1'b0;
            end
        end
    end

    assign bus_drive  = drive_q;
    assign busy       = (st_q != T_IDLE) || pend_q;
    assign won        = won_q;
    assign lost       = lost_q;
    assign brk_active = (st_q == T_BREAK);

    // R3: the line value changes only after a tick
    a_r3_drive_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(drive_q));

    // R2: a byte is only taken while idle or while holding the line
    a_r2_accept_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(idle_in || won_q));

    // R4: a node that lost keeps the line released
    a_r4_lost_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_LOST) |-> drive_q);

    // R8: won and lost never coexist
    a_r8_won_lost_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(won_q && lost_q));

    // R9: break slots are dominant
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_BREAK) |-> !drive_q);

    // R10: a break only begins when none was used under this request
    a_r10_single_break: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == T_BREAK) |-> !$past(used_q));

endmodule

// File: rtl/sbarb_node.sv
module sbarb_node
    import sbarb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 4,
    parameter int BRK_AFTER = 3,
    parameter int BRK_BITS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              idle_in,
    input  logic              brk_req,
    input  logic              rx_bit,
    output logic              bus_drive,
    output logic              busy,
    output logic              won,
    output logic              lost,
    output logic              brk_active,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic [CNT_W-1:0]  byte_count
);
    logic in_gap;
    logic at_stop;

    sbarb_rx #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rx_bit     (rx_bit),
        .idle_in    (idle_in),
        .in_gap     (in_gap),
        .at_stop    (at_stop),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .byte_count (byte_count)
    );

    sbarb_tx #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .BRK_AFTER (BRK_AFTER),
        .BRK_BITS  (BRK_BITS)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rx_bit     (rx_bit),
        .idle_in    (idle_in),
        .in_gap     (in_gap),
        .at_stop    (at_stop),
        .byte_count (byte_count),
        .tx_start   (tx_start),
        .tx_data    (tx_data),
        .brk_req    (brk_req),
        .bus_drive  (bus_drive),
        .busy       (busy),
        .won        (won),
        .lost       (lost),
        .brk_active (brk_active)
    );

    // R1: a node that is neither sending nor breaking leaves the line at mark
    a_r1_mark_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> bus_drive);

endmodule

// File: tb/sbarb_node_tb.sv
module sbarb_node_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = 3;
    localparam int BRK_AFTER  = 3;
    localparam int BRK_BITS   = 10;
    localparam int TICK_DIV   = 4;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic bit_tick;
    logic tx_start;
    logic [DATA_W-1:0] tx_data;
    logic idle_in;
    logic brk_req;
    logic rx_r;
    logic bus_drive, busy, won, lost, brk_active, rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic [CNT_W-1:0]  byte_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int divcnt = 0;
    int brk_rises = 0;
    logic prev_brk = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbarb_node #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .BRK_AFTER(BRK_AFTER), .BRK_BITS(BRK_BITS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_start(tx_start),
        .tx_data(tx_data), .idle_in(idle_in), .brk_req(brk_req), .rx_bit(rx_r),
        .bus_drive(bus_drive), .busy(busy), .won(won), .lost(lost),
        .brk_active(brk_active), .rx_valid(rx_valid), .rx_data(rx_data),
        .byte_count(byte_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- opponent node on the wired-AND line ----------------
    int   opp_q[$];
    logic opp_drv;
    logic opp_quiet;

    always @(posedge clk) begin
        if (!rst_n) begin
            opp_drv   <= 1'b1;
            opp_quiet <= 1'b0;
        end else if (bit_tick) begin
            logic q;
            int   v;
            q = opp_quiet || (opp_drv && !rx_r);
            if (opp_q.size() == 0) begin
                opp_drv   <= 1'b1;
                opp_quiet <= 1'b0;
            end else begin
                v = opp_q.pop_front();
                if (v == 2) begin
                    opp_drv   <= 1'b1;
                    opp_quiet <= 1'b0;
                end else begin
                    opp_drv   <= q ? 1'b1 : v[0];
                    opp_quiet <= q;
                end
            end
        end
    end

    // line value and tick generation, away from the active edge
    always @(negedge clk) begin
        rx_r     = bus_drive & opp_drv;
        bit_tick = (divcnt == 0);
        divcnt   = (divcnt + 1) % TICK_DIV;
    end

    // ---------------- behavioural reference model ----------------
    int m_st;            // 0 idle 1 start 2 data 3 stop 4 lost 5 break
    bit m_pend, m_drive, m_won, m_lost, m_used;
    logic [DATA_W-1:0] m_buf;
    int m_idx, m_bcnt;
    int r_st, r_idx, r_cnt;          // 0 gap 1 data 2 stop
    logic [DATA_W-1:0] r_sh, r_data;
    bit r_valid;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_drive = 1; m_won = 0; m_lost = 0; m_used = 0;
            m_buf = '0; m_idx = 0; m_bcnt = 0;
            r_st = 0; r_idx = 0; r_cnt = 0; r_sh = '0; r_data = '0; r_valid = 0;
        end else begin
            bit o_gap, o_stop, acc, fok;
            int o_cnt;
            o_gap  = (r_st == 0);
            o_stop = (r_st == 2);
            o_cnt  = r_cnt;
            acc = tx_start && m_st == 0 && !m_pend && (idle_in || m_won);
            fok = bit_tick && r_st == 2 && rx_r;
            r_valid = fok;
            if (fok) r_data = r_sh;
            if (bit_tick) begin
                case (r_st)
                    0: if (!rx_r) begin r_st = 1; r_idx = 0; end
                    1: begin
                        r_sh = {r_sh[DATA_W-2:0], rx_r};
                        if (r_idx == DATA_W-1) r_st = 2; else r_idx++;
                    end
                    default: r_st = 0;
                endcase
            end
            if (idle_in) r_cnt = 0;
            else if (fok && r_cnt < CMAX) r_cnt++;
            if (bit_tick) begin
                case (m_st)
                    0: begin
                        if (brk_req && !m_used && o_gap && o_cnt >= BRK_AFTER) begin
                            m_st = 5; m_drive = 0; m_bcnt = 0; m_used = 1;
                        end else if (m_pend && o_gap && rx_r) begin
                            m_st = 1; m_drive = 0; m_pend = 0;
                        end
                    end
                    1: begin
                        m_st = 2; m_drive = m_buf[DATA_W-1]; m_buf = m_buf << 1; m_idx = 0;
                    end
                    2: begin
                        if (m_drive && !rx_r) begin
                            m_st = 4; m_drive = 1; m_lost = 1; m_won = 0;
                        end else if (m_idx == DATA_W-1) begin
                            m_st = 3; m_drive = 1;
                        end else begin
                            m_drive = m_buf[DATA_W-1]; m_buf = m_buf << 1; m_idx++;
                        end
                    end
                    3: begin
                        m_st = 0; m_drive = 1;
                        if (!rx_r) begin m_lost = 1; m_won = 0; end
                        else m_won = 1;
                    end
                    4: if (o_stop) m_st = 0;
                    5: begin
                        if (m_bcnt == BRK_BITS-1) begin m_st = 0; m_drive = 1; end
                        else m_bcnt++;
                    end
                    default: m_st = 0;
                endcase
            end
            if (acc) begin m_pend = 1; m_buf = tx_data; end
            if (!brk_req) m_used = 0;
            if (idle_in) begin m_won = 0; m_lost = 0; end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 bus_drive", int'(bus_drive), int'(m_drive));
            chk("R2 busy", int'(busy), int'(m_st != 0 || m_pend));
            chk("R5 won", int'(won), int'(m_won));
            chk("R4 lost", int'(lost), int'(m_lost));
            chk("R9 brk_active", int'(brk_active), int'(m_st == 5));
            chk("R7 byte_count", int'(byte_count), r_cnt);
            chk("R6 rx_valid", int'(rx_valid), int'(r_valid));
            if (r_valid) chk("R6 rx_data", int'(rx_data), int'(r_data));
            if (brk_active && !prev_brk) brk_rises++;
            prev_brk = brk_active;
        end
    end

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic send(input logic [DATA_W-1:0] b);
        @(negedge clk);
        tx_data  = b;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic push_opp(input logic [DATA_W-1:0] b);
        opp_q.push_back(0);
        for (int i = DATA_W-1; i >= 0; i--) opp_q.push_back(int'(b[i]));
        opp_q.push_back(1);
        opp_q.push_back(2);
    endtask

    task automatic idle_pulse();
        @(negedge clk);
        idle_in = 1'b1;
        @(negedge clk);
        idle_in = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; tx_start = 1'b0; tx_data = '0; idle_in = 1'b0; brk_req = 1'b0;
        rx_r = 1'b1; bit_tick = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset bus_drive", int'(bus_drive), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset won", int'(won), 0);
        chk("R1 reset lost", int'(lost), 0);
        chk("R1 reset brk_active", int'(brk_active), 0);
        chk("R1 reset byte_count", int'(byte_count), 0);
        rst_n = 1'b1;
        wait_ticks(2);

        // R5: win an uncontested frame while idle, then chain one more
        idle_in = 1'b1;
        send(8'hA5);
        wait_ticks(1);
        idle_in = 1'b0;
        wait_ticks(12);
        chk("R5 won after clean frame", int'(won), 1);
        chk("R6 rx_data own frame", int'(rx_data), 'hA5);
        send(8'h3C);
        wait_ticks(13);
        chk("R7 two frames counted", int'(byte_count), 2);

        // R2: start ignored without idle and without holding the line
        idle_pulse();
        send(8'h77);
        @(negedge clk);
        chk("R2 rejected start busy", int'(busy), 0);
        wait_ticks(4);
        chk("R2 rejected start line", int'(bus_drive), 1);

        // R4: lose to a lower byte at bit 5
        idle_in = 1'b1;
        send(8'h34);
        push_opp(8'h12);
        wait_ticks(1);
        idle_in = 1'b0;
        wait_ticks(12);
        chk("R4 lost flag", int'(lost), 1);
        chk("R4 won cleared", int'(won), 0);
        chk("R6 rx_data winner byte", int'(rx_data), 'h12);
        send(8'h55);
        @(negedge clk);
        chk("R8 lost node cannot restart", int'(busy), 0);
        idle_pulse();
        @(negedge clk);
        chk("R8 idle clears lost", int'(lost), 0);

        // R5: beat the opponent
        idle_in = 1'b1;
        send(8'h05);
        push_opp(8'h40);
        wait_ticks(1);
        idle_in = 1'b0;
        wait_ticks(12);
        chk("R5 won over opponent", int'(won), 1);
        chk("R6 rx_data 05", int'(rx_data), 'h05);

        // R9 R10: break into a long stream after three frames
        idle_pulse();
        brk_req = 1'b1;
        brk_rises = 0;
        for (int k = 0; k < 6; k++) push_opp(8'h81 + 8'(k));
        wait_ticks(75);
        chk("R9 break produced", int'(brk_rises >= 1), 1);
        chk("R10 only one break", brk_rises, 1);
        chk("R7 break frame not counted", int'(byte_count), 5);
        brk_req = 1'b0;
        wait_ticks(2);
        idle_pulse();

        // R7: saturation
        for (int k = 0; k < 9; k++) push_opp(8'h5A);
        wait_ticks(105);
        chk("R7 saturated", int'(byte_count), CMAX);
        idle_pulse();
        @(negedge clk);
        chk("R7 idle clears count", int'(byte_count), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule